// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core that finishes each instruction in one clock cycle. It supports six register-to-register operations: add, subtract, and, or, nor and signed set-less-than. It also supports word load, word store, branch-if-equal and an absolute jump. The program counter and the register file are the only state inside the core. Decode, operand read, ALU work, the data-memory access and the choice of write-back value are all combinational and settle within the cycle.

The core talks to two memories. It drives an instruction address and takes back a 32-bit instruction word in the same cycle. It drives a data address, write data and read/write strobes to a data memory that answers a read in the same cycle and commits a write on the rising edge. Addresses are byte addresses, and every instruction is four bytes long.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter (`imem_addr`) becomes 0. Reset is synchronous and active high.
- R2: An instruction that is neither a taken branch nor a jump advances `imem_addr` by 4 at the next rising edge.
- R3: An instruction with opcode 0x00 and shift field 0 writes register `rd` (bits 15:11) with `rs` op `rt`. Register `rs` is in bits 25:21 and `rt` in bits 20:16. The operation is chosen by bits 5:0: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x27 nor, 0x2A signed less-than (result 1 or 0). Example: with 0xDCBA in `rs` and 0x4321 in `rt`, an add at 0x1220 writes 0x11FDB and leaves the PC at 0x1224.
- R4: Register 0 always reads as zero, and writes to it are dropped.
- R5: Load word (opcode 0x23) reads data memory at `rs` plus the sign-extended 16-bit offset (bits 15:0). It asserts `dmem_re` and writes the returned word into `rt`.
- R6: Store word (opcode 0x2B) asserts `dmem_we` with address `rs` plus the sign-extended offset and with `rt` as write data. It writes no register.
- R7: Branch-if-equal (opcode 0x04) sets the next PC to PC+4 plus the sign-extended offset shifted left by 2 when `rs` equals `rt`, and to PC+4 otherwise. It writes neither a register nor memory.
- R8: Jump (opcode 0x02) sets the next PC to bits 31:28 of PC+4, followed by the 26-bit field (bits 25:0), followed by two zero bits.
- R9: An unsupported opcode, an unsupported function code, or a nonzero shift field on opcode 0x00 changes no register and no memory, and the PC advances by 4.
- R10: `dmem_re` is high only for a load and `dmem_we` only for a store. A register write never happens together with a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, combinational |

## Verification
The register file has no port of its own. Every register value, including the proof that register 0 stayed zero and that an unsupported encoding wrote nothing, can only be seen by storing it afterwards. The program therefore ends each group of operations with stores, and a behavioural model predicts the address and data of every store in the cycle the store is made. The add example at 0x1220 lies far from reset, so it is reached with a jump whose target field is 0x488. A taken branch also jumps over a store that must never show up in data memory.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;
    localparam int IMMW = 16;
    localparam int JIDX = 26;

    typedef enum logic [5:0] {
        OPC_REG  = 6'h00,
        OPC_JMP  = 6'h02,
        OPC_BEQ  = 6'h04,
        OPC_LOAD = 6'h23,
        OPC_STOR = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_NOR = 6'h27,
        FN_SLT = 6'h2A
    } funct_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FIELD = 2'b10
    } aop_e;

    typedef enum logic [1:0] {
        OUT_AND = 2'b00,
        OUT_OR  = 2'b01,
        OUT_SUM = 2'b10,
        OUT_LT  = 2'b11
    } alu_out_e;

    typedef struct packed {
        logic     inv_a;
        logic     neg_b;
        alu_out_e out;
    } alu_ctl_t;

    typedef struct packed {
        logic dst_rd;
        logic b_imm;
        logic wb_mem;
        logic rf_wr;
        logic mem_rd;
        logic mem_wr;
        logic is_beq;
        logic is_jmp;
        aop_e aop;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]      op;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [4:0]      shamt;
        logic [5:0]      fn;
    } ifields_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] far_target(input logic [XLEN-1:0] seq_pc,
                                                   input logic [JIDX-1:0] idx);
        return {seq_pc[XLEN-1:JIDX+2], idx, 2'b00};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.aop = AOP_ADD;
        case (opcode)
            OPC_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.rf_wr  = 1'b1;
                ctrl.aop    = AOP_FIELD;
            end
            OPC_LOAD: begin
                ctrl.b_imm  = 1'b1;
                ctrl.wb_mem = 1'b1;
                ctrl.rf_wr  = 1'b1;
                ctrl.mem_rd = 1'b1;
            end
            OPC_STOR: begin
                ctrl.b_imm  = 1'b1;
                ctrl.mem_wr = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_beq = 1'b1;
                ctrl.aop    = AOP_SUB;
            end
            OPC_JMP: begin
                ctrl.is_jmp = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  aop_e         aop,
    input  logic [5:0]   fn,
    input  logic [4:0]   shamt,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         fn_ok
);
    alu_ctl_t       cs;
    logic [W-1:0]   a_m, b_m, sum;
    logic           lt;

    always_comb begin
        cs    = '{inv_a: 1'b0, neg_b: 1'b0, out: OUT_SUM};
        fn_ok = 1'b1;
        case (aop)
            AOP_ADD: cs = '{inv_a: 1'b0, neg_b: 1'b0, out: OUT_SUM};
            AOP_SUB: cs = '{inv_a: 1'b0, neg_b: 1'b1, out: OUT_SUM};
            AOP_FIELD: begin
                fn_ok = (shamt == 5'd0);
                case (fn)
                    FN_ADD: cs = '{inv_a: 1'b0, neg_b: 1'b0, out: OUT_SUM};
                    FN_SUB: cs = '{inv_a: 1'b0, neg_b: 1'b1, out: OUT_SUM};
                    FN_AND: cs = '{inv_a: 1'b0, neg_b: 1'b0, out: OUT_AND};
                    FN_OR:  cs = '{inv_a: 1'b0, neg_b: 1'b0, out: OUT_OR};
                    FN_NOR: cs = '{inv_a: 1'b1, neg_b: 1'b1, out: OUT_AND};
                    FN_SLT: cs = '{inv_a: 1'b0, neg_b: 1'b1, out: OUT_LT};
                    default: fn_ok = 1'b0;
                endcase
            end
            default: fn_ok = 1'b0;
        endcase
    end

    always_comb begin
        a_m  = cs.inv_a ? ~a : a;
        b_m  = cs.neg_b ? ~b : b;
        sum  = a_m + b_m + {{(W-1){1'b0}}, cs.neg_b};
        lt   = (a[W-1] ^ b[W-1]) ? a[W-1] : sum[W-1];
        case (cs.out)
            OUT_AND: y = a_m & b_m;
            OUT_OR:  y = a_m | b_m;
            OUT_SUM: y = sum;
            OUT_LT:  y = {{(W-1){1'b0}}, lt};
            default: y = sum;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int NREG = 32,
    parameter int W    = XLEN,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [NREG];

    assign regs[0] = '0;

    for (genvar i = 1; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && (wa == AW'(i)))
                regs[i] <= wd;
        end
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];

    assert_r0_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (ra_addr == '0) |-> (ra_data == '0));
    assert_r0_write_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        (we && wa == '0 && rb_addr == '0) |=> (rb_addr != '0) || (rb_data == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    output logic            dmem_re,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam int ISTEP = 4;

    logic [XLEN-1:0] pc_q, pc_seq, pc_nxt, br_tgt, jmp_tgt;
    ifields_t        f;
    logic [IMMW-1:0] imm;
    logic [JIDX-1:0] jidx;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_y, wb_val;
    logic            alu_zero, fn_ok, rf_we, br_take;
    logic [RIDX-1:0] wr_idx;

    assign f    = imem_rdata;
    assign imm  = imem_rdata[IMMW-1:0];
    assign jidx = imem_rdata[JIDX-1:0];

    sc_decode u_dec (
        .opcode (f.op),
        .ctrl   (ctrl)
    );

    sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (f.rs),
        .ra_data (rs_val),
        .rb_addr (f.rt),
        .rb_data (rt_val),
        .we      (rf_we),
        .wa      (wr_idx),
        .wd      (wb_val)
    );

    assign imm_x = sext_imm(imm);
    assign alu_b = ctrl.b_imm ? imm_x : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .aop   (ctrl.aop),
        .fn    (f.fn),
        .shamt (f.shamt),
        .a     (rs_val),
        .b     (alu_b),
        .y     (alu_y),
        .zero  (alu_zero),
        .fn_ok (fn_ok)
    );

    assign wr_idx = ctrl.dst_rd ? f.rd : f.rt;
    assign wb_val = ctrl.wb_mem ? dmem_rdata : alu_y;
    assign rf_we  = ctrl.rf_wr && fn_ok;

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_wr;
    assign dmem_re    = ctrl.mem_rd;

    assign pc_seq  = pc_q + XLEN'(ISTEP);
    assign br_tgt  = pc_seq + (imm_x << 2);
    assign jmp_tgt = far_target(pc_seq, jidx);
    assign br_take = ctrl.is_beq && alu_zero;

    always_comb begin
        if (ctrl.is_jmp)
            pc_nxt = jmp_tgt;
        else if (br_take)
            pc_nxt = br_tgt;
        else
            pc_nxt = pc_seq;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_nxt;
    end

    assign imem_addr = pc_q;

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.is_jmp && !br_take) |=> (pc_q == $past(pc_q) + XLEN'(ISTEP)));
    assert_beq_equal_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.is_beq && rs_val == rt_val) |=>
            (pc_q == $past(pc_q) + XLEN'(ISTEP) + ($past(imm_x) << 2)));
    assert_jump_region_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl.is_jmp |=> (pc_q[1:0] == 2'b00) &&
            (pc_q[XLEN-1:JIDX+2] == $past(pc_seq[XLEN-1:JIDX+2])));
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(dmem_we && (rf_we || dmem_re)));
    assert_no_write_bad_op_R9: assert property (@(posedge clk) disable iff (rst)
        (f.op == OPC_REG && f.shamt != 5'd0) |-> !rf_we);
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;

    always #10 clk = ~clk;

    logic [31:0] imem [0:2047];
    logic [31:0] dmem [0:63];
    logic [31:0] mdmem [0:63];
    logic [31:0] mreg [0:31];
    logic [31:0] mpc;
    int n_chk = 0;
    int n_bad = 0;
    int wp = 0;
    logic seen_1220 = 1'b0;

    assign imem_rdata = imem[imem_addr[12:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    sc_core u0 (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rt_w(input int rs, input int rt, input int rd,
                                         input int fn, input int sh = 0);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction
    function automatic logic [31:0] it_w(input int op, input int rs, input int rt,
                                         input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic emit(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    // expected outputs of the instruction at mpc, then advance the model
    task automatic model_cycle();
        logic [31:0] ins, a, b, ea, res, nxt;
        int op, fn, sh, rs, rt, rd;
        logic xwe, xre, wr;
        string tg;
        ins = imem[mpc[12:2]];
        op = int'(ins[31:26]); rs = int'(ins[25:21]); rt = int'(ins[20:16]);
        rd = int'(ins[15:11]); sh = int'(ins[10:6]); fn = int'(ins[5:0]);
        a = mreg[rs]; b = mreg[rt];
        ea = a + {{16{ins[15]}}, ins[15:0]};
        xwe = (op == 'h2B); xre = (op == 'h23);
        tg = xwe ? "R6" : (xre ? "R5" : "R10");
        check(imem_addr === mpc, "R2/R7/R8 pc", imem_addr, mpc);
        check(dmem_we === xwe, tg, 32'(dmem_we), 32'(xwe));
        check(dmem_re === xre, tg, 32'(dmem_re), 32'(xre));
        if (xwe || xre) check(dmem_addr === ea, tg, dmem_addr, ea);
        if (xwe) check(dmem_wdata === b, "R6 data", dmem_wdata, b);
        if (mpc == 32'h1220) seen_1220 = 1'b1;
        nxt = mpc + 4;
        wr = 1'b0; res = '0;
        case (op)
            'h00: if (sh == 0) begin
                wr = 1'b1;
                case (fn)
                    'h20: res = a + b;
                    'h22: res = a - b;
                    'h24: res = a & b;
                    'h25: res = a | b;
                    'h27: res = ~(a | b);
                    'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: wr = 1'b0;
                endcase
                if (wr && rd != 0) mreg[rd] = res;
            end
            'h23: if (rt != 0) mreg[rt] = mdmem[ea[7:2]];
            'h2B: mdmem[ea[7:2]] = b;
            'h04: if (a == b) nxt = mpc + 4 + ({{16{ins[15]}}, ins[15:0]} << 2);
            'h02: nxt = {nxt[31:28], ins[25:0], 2'b00};
            default: ;
        endcase
        mpc = nxt;
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) imem[i] = 32'hFC00_0000;
        for (int i = 0; i < 64; i++) begin dmem[i] = '0; mdmem[i] = '0; end
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        dmem[0] = 32'h0000DCBA; dmem[1] = 32'h00004321; dmem[2] = 32'h80000000;
        dmem[3] = 32'd5; dmem[4] = 32'hFFFFFFFD; dmem[5] = 32'd40;
        for (int i = 0; i < 64; i++) mdmem[i] = dmem[i];

        emit(it_w('h23, 0, 11, 0));  emit(it_w('h23, 0, 23, 4));
        emit(it_w('h23, 0, 5, 12));  emit(it_w('h23, 0, 6, 16));
        emit(it_w('h23, 0, 7, 8));   emit(it_w('h23, 0, 24, 20));
        emit(rt_w(5, 6, 0, 'h20));           // R4: write to r0 dropped
        emit(it_w('h2B, 0, 0, 32));          // store r0 -> word 8
        emit(rt_w(5, 6, 8, 'h22));           // R3 sub
        emit(rt_w(11, 23, 9, 'h24));
        emit(rt_w(11, 23, 10, 'h25));
        emit(rt_w(11, 23, 12, 'h27));
        emit(rt_w(6, 5, 13, 'h2A));
        emit(rt_w(5, 6, 14, 'h2A));
        emit(rt_w(7, 5, 15, 'h2A));
        emit(it_w('h2B, 0, 8, 52));  emit(it_w('h2B, 0, 9, 56));
        emit(it_w('h2B, 0, 10, 60)); emit(it_w('h2B, 0, 12, 64));
        emit(it_w('h2B, 0, 13, 68)); emit(it_w('h2B, 0, 14, 72));
        emit(it_w('h2B, 0, 15, 76));
        emit(it_w('h04, 5, 6, 5));           // R7 not taken
        emit(it_w('h04, 5, 5, 2));           // R7 taken, skips two
        emit(it_w('h2B, 0, 5, 80));
        emit(it_w('h2B, 0, 5, 84));
        emit(it_w('h3F, 0, 5, 0));           // R9 unknown opcode
        emit(rt_w(5, 5, 16, 'h3F));          // R9 unknown funct
        emit(rt_w(5, 5, 17, 'h20, 3));       // R9 nonzero shift field
        emit(it_w('h2B, 24, 8, -4));         // R5/R6 negative offset -> word 9
        emit({6'h02, 26'h488});              // R8 jump to 0x1220
        wp = 1160;
        emit(rt_w(11, 23, 19, 'h20));        // R3 example add
        emit(it_w('h2B, 0, 19, 44));
        emit(it_w('h2B, 0, 16, 48));
        emit(it_w('h2B, 0, 17, 88));
        emit(it_w('h04, 0, 0, -1));          // park

        mpc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr === 32'h0, "R1 reset pc", imem_addr, 32'h0);
        check(dmem_we === 1'b0, "R1 reset no store", 32'(dmem_we), 32'h0);
        rst = 1'b0;
        for (int c = 0; c < 70; c++) begin
            model_cycle();
            @(negedge clk);
        end
        check(seen_1220 === 1'b1, "R3 reached 0x1220", 32'(seen_1220), 32'h1);
        check(dmem[11] === 32'h00011FDB, "R3 add example", dmem[11], 32'h00011FDB);
        check(dmem[8] === 32'h0, "R4 r0 zero", dmem[8], 32'h0);
        check(dmem[9] === 32'd8, "R6 neg offset store", dmem[9], 32'd8);
        check(dmem[13] === 32'd8, "R3 sub", dmem[13], 32'd8);
        check(dmem[14] === 32'h4020, "R3 and", dmem[14], 32'h4020);
        check(dmem[15] === 32'hDFBB, "R3 or", dmem[15], 32'hDFBB);
        check(dmem[16] === 32'hFFFF2044, "R3 nor", dmem[16], 32'hFFFF2044);
        check(dmem[17] === 32'd1, "R3 slt neg<pos", dmem[17], 32'd1);
        check(dmem[18] === 32'd0, "R3 slt pos<neg", dmem[18], 32'd0);
        check(dmem[19] === 32'd1, "R3 slt min<5", dmem[19], 32'd1);
        check(dmem[20] === 32'd0, "R7 skipped store", dmem[20], 32'd0);
        check(dmem[21] === 32'd0, "R7 skipped store", dmem[21], 32'd0);
        check(dmem[12] === 32'd0, "R9 bad funct", dmem[12], 32'd0);
        check(dmem[22] === 32'd0, "R9 shift field", dmem[22], 32'd0);
        check(imem_addr === 32'h1230, "R7 park loop", imem_addr, 32'h1230);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R2 actual=0x%08h expected=0x%08h", imem_addr, mpc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule